// File: doc/BRIEF.md
# Fine-Trimmable Time-of-Day Counter

This block keeps a running time-of-day value, split into a 32-bit seconds field and a nanoseconds field, for use by hardware timestamping logic. It runs from a single reference clock whose frequency is set by the system. Software uses a few write strobes to choose how the time advances, to set the nanosecond step, to set a frequency-tuning addend, and to load a starting time.

Two advance modes exist. In coarse mode the nanosecond step is added on every clock. In fine mode a 32-bit phase accumulator adds the addend on every clock, and the time moves forward by the step only on cycles where that addition carries out of the top bit. Software therefore trims the frequency of the time base by rewriting the addend alone. The usual setting is a mid-range addend of 2^31 and a step of twice the clock period, so the time advances by two periods once every two cycles. A one-cycle tick output marks each cycle in which the visible time has just moved.

Top module: `ptp_tod_counter`

## Requirements
- R1: After reset the seconds and nanoseconds outputs read 0 and tick reads 0. The mode is coarse (0), the step is 0, and the addend is 2^31.
- R2: A configuration write (`cfg_wr_i` high) latches the mode (`cfg_fine_i`: 1 = fine, 0 = coarse) and the 8-bit nanosecond step. These take effect from the next clock. In coarse mode the step is added to the nanoseconds on every clock.
- R3: In fine mode the addend is added to a 32-bit accumulator on every clock. The step is added to the nanoseconds only on clocks where that sum carries out of bit 31.
- R4: With an addend of 2^31 and the accumulator cleared, carries come on every second clock, starting with the second clock after the load. With an 80 ns step, 100 clocks advance the time by exactly 4000 ns.
- R5: In fine mode an addend of 0 never carries. The time holds still and tick stays 0.
- R6: Starting from a cleared accumulator, the number of advances over N clocks equals floor(N*addend/2^32). An addend above 2^31 therefore gives more advances than mid-range, and an addend below 2^31 gives fewer.
- R7: When nanoseconds plus the step would reach or pass 1,000,000,000, the nanoseconds become the sum minus 1,000,000,000 and the seconds increment in the same clock.
- R8: The seconds field wraps from 2^32-1 to 0 on a rollover.
- R9: A load strobe (`init_i`) puts the supplied seconds and nanoseconds on the outputs on the next clock. It also clears the accumulator, suppresses any advance on that clock, and leaves tick at 0.
- R10: An addend write (`addend_wr_i`) latches a new addend. The old addend is still used on the clock of the write, the new one is used from the next clock, and the accumulator contents are kept.
- R11: Tick is high exactly in the cycles in which the time output has just advanced by a nonzero step, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside |
| cfg_wr_i | input | 1 | Strobe that latches mode and step |
| cfg_fine_i | input | 1 | Mode to latch: 1 fine, 0 coarse |
| cfg_inc_i | input | 8 | Nanosecond step to latch |
| addend_wr_i | input | 1 | Strobe that latches the addend |
| addend_i | input | 32 | Frequency-tuning addend |
| init_i | input | 1 | Strobe that loads the time and clears the accumulator |
| init_sec_i | input | 32 | Seconds value to load |
| init_ns_i | input | 30 | Nanoseconds value to load (below 1e9) |
| tod_sec_o | output | 32 | Current seconds |
| tod_ns_o | output | 30 | Current nanoseconds |
| tick_o | output | 1 | One-cycle pulse when the time has just advanced |

## Verification
The bench sweeps addends from zero to all-ones over fixed windows and compares the advance count with floor(N*addend/2^32). If the carry were taken from the wrong bit, or the accumulator were not cleared on load, those counts would be wrong. It loads times just below the one-second boundary and at the largest seconds value. A design that compares with greater-than instead of greater-or-equal, or that delays the seconds carry by a cycle, would show a nanosecond value of 1e9 or a seconds value that is stale. It writes a new addend while the accumulator is half full. A design that applies the addend early or clears the accumulator on the write would then miss the carry on that clock.

// File: rtl/tod_pkg.sv
package tod_pkg;
  typedef enum logic {
    MODE_COARSE = 1'b0,
    MODE_FINE   = 1'b1
  } tod_mode_e;
endpackage

// File: rtl/tod_rst_sync.sv
module tod_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/tod_cfg_regs.sv
module tod_cfg_regs
  import tod_pkg::*;
#(
  parameter int INC_W = 8,
  parameter int ACC_W = 32,
  parameter logic [ACC_W-1:0] ADDEND_RST = ACC_W'(1) << (ACC_W-1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr_i,
  input  logic             cfg_fine_i,
  input  logic [INC_W-1:0] cfg_inc_i,
  input  logic             addend_wr_i,
  input  logic [ACC_W-1:0] addend_i,
  output tod_mode_e        mode_o,
  output logic [INC_W-1:0] inc_o,
  output logic [ACC_W-1:0] addend_o
);
  tod_mode_e        mode_q, mode_d;
  logic [INC_W-1:0] inc_q, inc_d;
  logic [ACC_W-1:0] add_q, add_d;

  always_comb begin
    mode_d = mode_q;
    inc_d  = inc_q;
    add_d  = add_q;
    if (cfg_wr_i) begin
      mode_d = cfg_fine_i ? MODE_FINE : MODE_COARSE;
      inc_d  = cfg_inc_i;
    end
    if (addend_wr_i) add_d = addend_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_COARSE;
      inc_q  <= '0;
      add_q  <= ADDEND_RST;
    end else begin
      mode_q <= mode_d;
      inc_q  <= inc_d;
      add_q  <= add_d;
    end
  end

  assign mode_o   = mode_q;
  assign inc_o    = inc_q;
  assign addend_o = add_q;
endmodule

// File: rtl/tod_phase_acc.sv
module tod_phase_acc #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [ACC_W-1:0] addend_i,
  output logic             carry_o
);
  logic [ACC_W-1:0] acc_q, acc_d;
  logic [ACC_W:0]   sum;

  always_comb begin
    sum   = {1'b0, acc_q} + {1'b0, addend_i};
    acc_d = acc_q;
    if (clr_i)     acc_d = '0;
    else if (en_i) acc_d = sum[ACC_W-1:0];
    carry_o = en_i & ~clr_i & sum[ACC_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end
endmodule

// File: rtl/tod_time_regs.sv
module tod_time_regs #(
  parameter int SEC_W      = 32,
  parameter int NS_W       = 30,
  parameter int INC_W      = 8,
  parameter int NS_PER_SEC = 1000000000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [SEC_W-1:0] load_sec_i,
  input  logic [NS_W-1:0]  load_ns_i,
  input  logic             step_i,
  input  logic [INC_W-1:0] inc_i,
  output logic [SEC_W-1:0] sec_o,
  output logic [NS_W-1:0]  ns_o,
  output logic             tick_o
);
  localparam int SUM_W = NS_W + 1;
  localparam logic [SUM_W-1:0] NS_LIM = SUM_W'(NS_PER_SEC);

  logic [SEC_W-1:0] sec_q, sec_d;
  logic [NS_W-1:0]  ns_q, ns_d;
  logic             tick_q, tick_d;
  logic [SUM_W-1:0] ns_sum, ns_adv;
  logic             roll;

  always_comb begin
    ns_sum = {1'b0, ns_q} + SUM_W'(inc_i);
    roll   = (ns_sum >= NS_LIM);
    ns_adv = roll ? (ns_sum - NS_LIM) : ns_sum;
    sec_d  = sec_q;
    ns_d   = ns_q;
    tick_d = 1'b0;
    if (load_i) begin
      sec_d = load_sec_i;
      ns_d  = load_ns_i;
    end else if (step_i) begin
      ns_d   = NS_W'(ns_adv);
      tick_d = (inc_i != '0);
      if (roll) sec_d = sec_q + SEC_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q  <= '0;
      ns_q   <= '0;
      tick_q <= 1'b0;
    end else begin
      sec_q  <= sec_d;
      ns_q   <= ns_d;
      tick_q <= tick_d;
    end
  end

  assign sec_o  = sec_q;
  assign ns_o   = ns_q;
  assign tick_o = tick_q;
endmodule

// File: rtl/ptp_tod_counter.sv
module ptp_tod_counter
  import tod_pkg::*;
#(
  parameter int SEC_W      = 32,
  parameter int NS_W       = 30,
  parameter int INC_W      = 8,
  parameter int ACC_W      = 32,
  parameter int NS_PER_SEC = 1000000000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr_i,
  input  logic             cfg_fine_i,
  input  logic [INC_W-1:0] cfg_inc_i,
  input  logic             addend_wr_i,
  input  logic [ACC_W-1:0] addend_i,
  input  logic             init_i,
  input  logic [SEC_W-1:0] init_sec_i,
  input  logic [NS_W-1:0]  init_ns_i,
  output logic [SEC_W-1:0] tod_sec_o,
  output logic [NS_W-1:0]  tod_ns_o,
  output logic             tick_o
);
  localparam logic [ACC_W-1:0] ADDEND_MID = ACC_W'(1) << (ACC_W-1);

  logic             rst_n_s;
  tod_mode_e        mode;
  logic [INC_W-1:0] inc;
  logic [ACC_W-1:0] addend;
  logic             carry;
  logic             step;
  logic             fine_en;

  tod_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_s)
  );

  tod_cfg_regs #(
    .INC_W(INC_W), .ACC_W(ACC_W), .ADDEND_RST(ADDEND_MID)
  ) u_cfg (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .cfg_wr_i    (cfg_wr_i),
    .cfg_fine_i  (cfg_fine_i),
    .cfg_inc_i   (cfg_inc_i),
    .addend_wr_i (addend_wr_i),
    .addend_i    (addend_i),
    .mode_o      (mode),
    .inc_o       (inc),
    .addend_o    (addend)
  );

  assign fine_en = (mode == MODE_FINE);

  tod_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .clr_i    (init_i),
    .en_i     (fine_en),
    .addend_i (addend),
    .carry_o  (carry)
  );

  always_comb begin
    if (fine_en) step = carry;
    else         step = ~init_i;
  end

  tod_time_regs #(
    .SEC_W(SEC_W), .NS_W(NS_W), .INC_W(INC_W), .NS_PER_SEC(NS_PER_SEC)
  ) u_time (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .load_i     (init_i),
    .load_sec_i (init_sec_i),
    .load_ns_i  (init_ns_i),
    .step_i     (step),
    .inc_i      (inc),
    .sec_o      (tod_sec_o),
    .ns_o       (tod_ns_o),
    .tick_o     (tick_o)
  );
endmodule

// File: rtl/tod_counter_chk.sv
module tod_counter_chk #(
  parameter int SEC_W      = 32,
  parameter int NS_W       = 30,
  parameter int NS_PER_SEC = 1000000000
) (
  input logic             clk,
  input logic             rst_n,
  input logic             init_i,
  input logic [SEC_W-1:0] init_sec_i,
  input logic [NS_W-1:0]  init_ns_i,
  input logic [SEC_W-1:0] tod_sec_o,
  input logic [NS_W-1:0]  tod_ns_o,
  input logic             tick_o
);
  localparam logic [NS_W-1:0] LIM = NS_W'(NS_PER_SEC);

  a_r9_load: assert property (@(posedge clk) disable iff (!rst_n)
    init_i |=> (tod_sec_o == $past(init_sec_i)) && (tod_ns_o == $past(init_ns_i)) && !tick_o);

  a_r7_ns_range: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_i && tod_ns_o < LIM) |=> (tod_ns_o < LIM));

  a_r8_sec_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && tod_sec_o != $past(tod_sec_o)) |-> (tod_sec_o == SEC_W'($past(tod_sec_o) + SEC_W'(1))));

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_o && !$past(init_i)) |-> ($stable(tod_ns_o) && $stable(tod_sec_o)));

  a_r11_moved: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> (tod_ns_o != $past(tod_ns_o) || tod_sec_o != $past(tod_sec_o)));
endmodule

bind ptp_tod_counter tod_counter_chk #(
  .SEC_W(SEC_W), .NS_W(NS_W), .NS_PER_SEC(NS_PER_SEC)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .init_i     (init_i),
  .init_sec_i (init_sec_i),
  .init_ns_i  (init_ns_i),
  .tod_sec_o  (tod_sec_o),
  .tod_ns_o   (tod_ns_o),
  .tick_o     (tick_o)
);

// File: tb/sim_ptp_tod_counter.sv
`timescale 1ns/1ps
module sim_ptp_tod_counter;
  localparam int unsigned NSPS = 1000000000;

  logic        clk;
  logic        rst_n;
  logic        cfg_wr, cfg_fine, addend_wr, init;
  logic [7:0]  cfg_inc;
  logic [31:0] addend, init_sec, tod_sec;
  logic [29:0] init_ns, tod_ns;
  logic        tick;

  int total, bad, tick_cnt;
  string cur_req;

  // bench model state
  logic        m_fine;
  logic [7:0]  m_inc;
  logic [31:0] m_add, m_acc, m_sec;
  int unsigned m_ns;
  logic        m_tick;

  ptp_tod_counter u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr_i(cfg_wr), .cfg_fine_i(cfg_fine), .cfg_inc_i(cfg_inc),
    .addend_wr_i(addend_wr), .addend_i(addend),
    .init_i(init), .init_sec_i(init_sec), .init_ns_i(init_ns),
    .tod_sec_o(tod_sec), .tod_ns_o(tod_ns), .tick_o(tick)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic report();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    report();
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_edge();
    logic [32:0] s;
    bit stp;
    int unsigned nn;
    if (init) begin
      m_sec = init_sec; m_ns = init_ns; m_acc = '0; m_tick = 1'b0;
    end else begin
      if (m_fine) begin
        s = {1'b0, m_acc} + {1'b0, m_add};
        stp = s[32]; m_acc = s[31:0];
      end else stp = 1'b1;
      m_tick = stp && (m_inc != 0);
      if (stp) begin
        nn = m_ns + m_inc;
        if (nn >= NSPS) begin nn = nn - NSPS; m_sec = m_sec + 1; end
        m_ns = nn;
      end
    end
    if (cfg_wr) begin m_fine = cfg_fine; m_inc = cfg_inc; end
    if (addend_wr) m_add = addend;
  endtask

  task automatic cyc();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    if (tick) tick_cnt++;
    chk(tod_sec == m_sec, {cur_req, " seconds"}, tod_sec, m_sec);
    chk(tod_ns == 30'(m_ns), {cur_req, " nanoseconds"}, tod_ns, m_ns);
    chk(tick == m_tick, {cur_req, " R11 tick"}, tick, m_tick);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic do_cfg(input bit f, input logic [7:0] inc);
    cfg_fine = f; cfg_inc = inc; cfg_wr = 1'b1; cyc(); cfg_wr = 1'b0;
  endtask

  task automatic do_add(input logic [31:0] a);
    addend = a; addend_wr = 1'b1; cyc(); addend_wr = 1'b0;
  endtask

  task automatic do_init(input logic [31:0] s, input logic [29:0] n);
    init_sec = s; init_ns = n; init = 1'b1; cyc(); init = 1'b0;
  endtask

  initial begin
    total = 0; bad = 0; tick_cnt = 0; cur_req = "R1";
    rst_n = 1'b0; cfg_wr = 0; cfg_fine = 0; cfg_inc = 0;
    addend_wr = 0; addend = 0; init = 0; init_sec = 0; init_ns = 0;
    m_fine = 0; m_inc = 0; m_add = 32'h8000_0000; m_acc = 0; m_sec = 0; m_ns = 0; m_tick = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    run(4);
    // R1 reset values at the ports
    chk(tod_sec == 0 && tod_ns == 0 && tick == 0, "R1 reset outputs", {tod_sec, tod_ns}, 0);

    // R1 reset addend is mid-range: fine mode without an addend write
    cur_req = "R1";
    do_cfg(1, 10);
    do_init(0, 0);
    tick_cnt = 0;
    run(20);
    chk(tick_cnt == 10, "R1 reset addend mid-range", tick_cnt, 10);

    // R2 coarse stepping with several steps
    cur_req = "R2";
    do_cfg(0, 8);   run(50);
    do_cfg(0, 40);  run(30);
    do_cfg(0, 255); run(20);
    do_init(3, 0);
    run(10);
    chk(tod_ns == 2550, "R2 coarse ten steps of 255", tod_ns, 2550);

    // R9 load
    cur_req = "R9";
    do_init(5, 100);
    chk(tod_sec == 5 && tod_ns == 100 && tick == 0, "R9 load", tod_ns, 100);

    // R3/R4 fine mid-range, 25 MHz style step of 80 ns
    cur_req = "R4";
    do_cfg(1, 80);
    do_add(32'h8000_0000);
    do_init(0, 0);
    tick_cnt = 0;
    cyc();
    chk(tick == 0, "R4 no carry on first clock", tick, 0);
    cyc();
    chk(tick == 1, "R4 carry on second clock", tick, 1);
    run(98);
    chk(tick_cnt == 50, "R4 carry count", tick_cnt, 50);
    chk(tod_ns == 4000, "R3 fine advance 4000 ns", tod_ns, 4000);

    // R5 zero addend freezes time
    cur_req = "R5";
    do_add(32'h0);
    tick_cnt = 0;
    run(100);
    chk(tick_cnt == 0 && tod_ns == 30'(m_ns), "R5 frozen", tick_cnt, 0);

    // R6 addend sweep
    cur_req = "R6";
    for (int k = 0; k <= 16; k++) begin
      logic [31:0] a;
      longint exp;
      a = (k == 16) ? 32'hFFFF_FFFF : (32'(k) << 28);
      do_add(a);
      do_init(0, 0);
      tick_cnt = 0;
      run(32);
      exp = (longint'(32) * longint'(a)) >>> 32;
      chk(longint'(tick_cnt) == exp, "R6 advances vs addend", tick_cnt, exp);
    end

    // R7 rollover near the second boundary, several steps
    cur_req = "R7";
    for (int inc = 1; inc <= 255; inc += 37) begin
      do_cfg(0, 8'(inc));
      do_init(7, 30'(NSPS - 3 * inc + 1));
      run(4);
    end
    do_cfg(0, 40);
    do_init(0, 30'(NSPS - 50));
    cyc();
    chk(tod_ns == 30'(NSPS - 10) && tod_sec == 0, "R7 before boundary", tod_ns, NSPS - 10);
    cyc();
    chk(tod_ns == 30 && tod_sec == 1, "R7 rollover", tod_ns, 30);
    do_init(0, 30'(NSPS - 40));
    cyc();
    chk(tod_ns == 0 && tod_sec == 1, "R7 exact boundary", tod_ns, 0);

    // R8 seconds wrap
    cur_req = "R8";
    do_cfg(0, 20);
    do_init(32'hFFFF_FFFF, 30'(NSPS - 10));
    cyc();
    chk(tod_sec == 0 && tod_ns == 10, "R8 seconds wrap", tod_sec, 0);

    // R10 addend write keeps accumulator, new value next clock
    cur_req = "R10";
    do_cfg(1, 16);
    do_add(32'h8000_0000);
    do_init(0, 0);
    cyc();                       // acc now half full, no carry
    do_add(32'h0);               // old addend still used: carry here
    chk(tick == 1, "R10 old addend on write clock", tick, 1);
    tick_cnt = 0;
    run(10);
    chk(tick_cnt == 0, "R10 new addend from next clock", tick_cnt, 0);
    do_add(32'h8000_0000);
    run(6);

    report();
  end
endmodule